// File: doc/BRIEF.md
# Truncating FMA Exponent Finalizer

This block forms the final biased exponent of a single-precision fused multiply-add that always rounds toward zero. It also drives the one-hot select lines of the result multiplexer. Three exponent terms are first reduced 3:2 and then fed to a compound adder. The adder delivers the sum together with the sum plus one and the sum plus two, so no downstream adder needs a carry-in. The leading-zero estimate `lz` from the anticipator is subtracted from these candidates through its one's complement.

The leading-zero estimate may be one too large. The block therefore builds two complete outcomes in parallel, each with its exponent, overflow, underflow and zero decisions: one for an exact estimate and one for an estimate that is one too large. The late error bit `lza_err` then chooses between the two finished outcomes just before the output register. All exponent arithmetic uses 10-bit two's complement with a bias of 127. Overflow therefore reduces to a check of the top two bits, and underflow reduces to the sign of the decremented exponent.

The number format has these properties:
- Overflow saturates to the largest magnitude.
- Results that would be denormal are flushed to zero.
- The biased value 255 is an ordinary normal binade.
- A flag marks results that were flushed or that landed in that top binade.

Top module: `fma_exp_finalizer`

## Requirements
- R1: All outputs are registered with a latency of one clock. While reset is active, every output is 0.
- R2: The candidate biased exponent is E = (exp_x + exp_y + exp_z) − lz + lza_err, evaluated modulo 1024 as a 10-bit two's-complement value.
- R3: When E ≥ 256 and no zero cause is present, the block asserts sel_max and drives res_exp = 8'hFF. This is saturation, not infinity.
- R4: When E ≤ 0, the block asserts sel_zero and drives res_exp = 0. The test for this case is the sign of E − 1.
- R5: When frac_zero = 1 or special_zero = 1, the block asserts sel_zero and drives res_exp = 0, whatever the value of E.
- R6: When 1 ≤ E ≤ 255 and no zero cause is present, the block asserts sel_norm and drives res_exp = E[7:0]. The value 255 counts as normal.
- R7: After reset, exactly one of sel_zero, sel_max and sel_norm is 1 in every cycle.
- R8: range_flag is 1 in exactly two cases:
  - E ≤ 0 while both frac_zero and special_zero are 0.
  - The result is normal with E = 255.
- R9: lza_err = 1 raises the exponent by exactly one relative to lza_err = 0, for every lz from 0 to 48. All flags and selects follow the chosen exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_x | input | 10 | First exponent term, two's complement |
| exp_y | input | 10 | Second exponent term, two's complement |
| exp_z | input | 10 | Third exponent term (bias correction), two's complement |
| lz | input | 6 | Leading-zero count estimated by the anticipator |
| lza_err | input | 1 | Late flag: the estimate was one too large |
| frac_zero | input | 1 | Fraction result is all zero |
| special_zero | input | 1 | Zero produced by special operands |
| res_exp | output | 8 | Final biased exponent field |
| sel_zero | output | 1 | Result mux: true zero |
| sel_max | output | 1 | Result mux: saturated maximum |
| sel_norm | output | 1 | Result mux: normal result |
| range_flag | output | 1 | Flushed-to-zero or top-binade indication |

## Verification
The checks rest on two assumptions about the inputs:
- The true sum of the three exponent terms lies between −400 and 400.
- The estimate lz never exceeds 48.

Under these assumptions E, E + 1 and E − 1 never leave the 10-bit range, so the two-bit overflow test and the sign-based underflow test are exact. The random stimulus first draws a sum inside that window. It then derives exp_z from the two random terms and wraps it to 10 bits, so the sum is still correct modulo 1024. Directed cases sit on E = 0, 1, 255 and 256 and sweep every lz from 0 to 48 with both error values.

// File: rtl/fma_exp_pkg.sv
package fma_exp_pkg;
  localparam int unsigned FEW = 8;          // result exponent field width
  localparam int unsigned XW  = FEW + 2;    // internal two's-complement width
  localparam int unsigned LZW = 6;          // leading-zero count width
  localparam int unsigned NCAND = 2;        // outcomes, one per anticipator error value

  typedef struct packed {
    logic [FEW-1:0] exp;
    logic           zero;
    logic           max;
    logic           norm;
    logic           flag;
  } fin_sel_t;
endpackage

// File: rtl/fma_exp_compound.sv
module fma_exp_compound
  import fma_exp_pkg::*;
(
  input  logic [XW-1:0] term_a,
  input  logic [XW-1:0] term_b,
  input  logic [XW-1:0] term_c,
  output logic [XW-1:0] sum0,
  output logic [XW-1:0] sum1,
  output logic [XW-1:0] sum2
);
  logic [XW-1:0] csa_s;
  logic [XW-1:0] csa_c;

  // 3:2 reduction into carry-save form
  always_comb begin
    csa_s = term_a ^ term_b ^ term_c;
    csa_c = {((term_a[XW-2:0] & term_b[XW-2:0]) |
              (term_a[XW-2:0] & term_c[XW-2:0]) |
              (term_b[XW-2:0] & term_c[XW-2:0])), 1'b0};
  end

  // compound adder: sum, sum+1, sum+2
  always_comb begin
    sum0 = csa_s + csa_c;
    sum1 = csa_s + csa_c + XW'(1);
    sum2 = csa_s + csa_c + XW'(2);
  end
endmodule

// File: rtl/fma_exp_outcome.sv
module fma_exp_outcome
  import fma_exp_pkg::*;
(
  input  logic [XW-1:0]  base_inc,   // candidate base + 1 (absorbs +1 of two's complement)
  input  logic [XW-1:0]  base_dec,   // candidate base     (gives exponent − 1)
  input  logic [LZW-1:0] lz,
  input  logic           frac_zero,
  input  logic           special_zero,
  output fin_sel_t       sel
);
  logic [XW-1:0] lz_inv;
  logic [XW-1:0] exp_c;
  logic [XW-1:0] exp_m1;
  logic          ovf;
  logic          unf;
  logic          zero_cause;
  logic          top_binade;

  always_comb begin
    lz_inv     = ~{{(XW-LZW){1'b0}}, lz};
    exp_c      = base_inc + lz_inv;      // base - lz
    exp_m1     = base_dec + lz_inv;      // base - lz - 1
    ovf        = (exp_c[XW-1:XW-2] == 2'b01);
    unf        = exp_m1[XW-1];
    zero_cause = frac_zero | special_zero;
    top_binade = (exp_c[XW-1:XW-2] == 2'b00) && (&exp_c[FEW-1:0]);

    sel.zero = unf | zero_cause;
    sel.max  = ovf & ~sel.zero;
    sel.norm = ~ovf & ~sel.zero;
    if (sel.zero)      sel.exp = '0;
    else if (ovf)      sel.exp = '1;
    else               sel.exp = exp_c[FEW-1:0];
    sel.flag = (unf & ~zero_cause) | (sel.norm & top_binade);
  end
endmodule

// File: rtl/fma_exp_finalizer.sv
module fma_exp_finalizer
  import fma_exp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [XW-1:0]  exp_x,
  input  logic [XW-1:0]  exp_y,
  input  logic [XW-1:0]  exp_z,
  input  logic [LZW-1:0] lz,
  input  logic           lza_err,
  input  logic           frac_zero,
  input  logic           special_zero,
  output logic [FEW-1:0] res_exp,
  output logic           sel_zero,
  output logic           sel_max,
  output logic           sel_norm,
  output logic           range_flag
);
  logic          rst_meta;
  logic          rst_q;
  logic [XW-1:0] e_sum [NCAND+1];
  fin_sel_t      outc  [NCAND];
  fin_sel_t      pick_d;
  fin_sel_t      pick_q;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  fma_exp_compound u_compound (
    .term_a (exp_x),
    .term_b (exp_y),
    .term_c (exp_z),
    .sum0   (e_sum[0]),
    .sum1   (e_sum[1]),
    .sum2   (e_sum[2])
  );

  // one complete outcome per anticipator error value
  for (genvar k = 0; k < NCAND; k++) begin : g_outc
    fma_exp_outcome u_outc (
      .base_inc     (e_sum[k+1]),
      .base_dec     (e_sum[k]),
      .lz           (lz),
      .frac_zero    (frac_zero),
      .special_zero (special_zero),
      .sel          (outc[k])
    );
  end

  // late selection ahead of the register
  always_comb begin
    pick_d = lza_err ? outc[1] : outc[0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) pick_q <= '0;
    else        pick_q <= pick_d;
  end

  assign res_exp    = pick_q.exp;
  assign sel_zero   = pick_q.zero;
  assign sel_max    = pick_q.max;
  assign sel_norm   = pick_q.norm;
  assign range_flag = pick_q.flag;
endmodule

// File: rtl/fma_exp_finalizer_chk.sv
module fma_exp_finalizer_chk
  import fma_exp_pkg::*;
(
  input logic           clk,
  input logic           rst_ok,
  input logic           frac_zero,
  input logic           special_zero,
  input logic [FEW-1:0] res_exp,
  input logic           sel_zero,
  input logic           sel_max,
  input logic           sel_norm,
  input logic           range_flag
);
  logic seen;
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_ok)
    seen |-> $onehot({sel_zero, sel_max, sel_norm}));

  a_r3_saturate_value: assert property (@(posedge clk) disable iff (!rst_ok)
    sel_max |-> (res_exp == '1));

  a_r4_zero_value: assert property (@(posedge clk) disable iff (!rst_ok)
    sel_zero |-> (res_exp == '0));

  a_r5_zero_cause: assert property (@(posedge clk) disable iff (!rst_ok)
    (frac_zero || special_zero) |=> sel_zero);

  a_r8_flag_context: assert property (@(posedge clk) disable iff (!rst_ok)
    range_flag |-> (sel_zero || (sel_norm && res_exp == '1)));

  a_r6_norm_nonzero: assert property (@(posedge clk) disable iff (!rst_ok)
    sel_norm |-> (res_exp != '0));
endmodule

bind fma_exp_finalizer fma_exp_finalizer_chk u_chk (
  .clk          (clk),
  .rst_ok       (rst_q),
  .frac_zero    (frac_zero),
  .special_zero (special_zero),
  .res_exp      (res_exp),
  .sel_zero     (sel_zero),
  .sel_max      (sel_max),
  .sel_norm     (sel_norm),
  .range_flag   (range_flag)
);

// File: tb/test_fma_exp_finalizer.sv
`timescale 1ns/1ps
module test_fma_exp_finalizer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] exp_x, exp_y, exp_z;
  logic [5:0] lz;
  logic       lza_err, frac_zero, special_zero;
  logic [7:0] res_exp;
  logic       sel_zero, sel_max, sel_norm, range_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fma_exp_finalizer i_fma_exp_finalizer (
    .clk(clk), .rst_n(rst_n), .exp_x(exp_x), .exp_y(exp_y), .exp_z(exp_z),
    .lz(lz), .lza_err(lza_err), .frac_zero(frac_zero), .special_zero(special_zero),
    .res_exp(res_exp), .sel_zero(sel_zero), .sel_max(sel_max),
    .sel_norm(sel_norm), .range_flag(range_flag)
  );

  function automatic logic [11:0] model(input int sum, input int l, input bit err,
                                        input bit fz, input bit sz);
    int  e;
    logic [7:0] ex;
    bit  z, m, n, f;
    e = sum - l + int'(err);
    z = (e <= 0) || fz || sz;
    m = !z && (e >= 256);
    n = !z && !m;
    ex = z ? 8'h00 : (m ? 8'hFF : 8'(e));
    f = ((e <= 0) && !fz && !sz) || (n && e == 255);
    return {ex, z, m, n, f};
  endfunction

  task automatic check(input string req, input logic [11:0] exp_v);
    logic [11:0] act;
    act = {res_exp, sel_zero, sel_max, sel_norm, range_flag};
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got exp=%h z/m/n/f=%b expected exp=%h z/m/n/f=%b",
               req, act[11:4], act[3:0], exp_v[11:4], exp_v[3:0]);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(input string req, input int sum, input int l, input bit err,
                       input bit fz, input bit sz);
    int x, y;
    x = int'($urandom_range(255, 0));
    y = int'($urandom_range(255, 0));
    exp_x = 10'(x); exp_y = 10'(y); exp_z = 10'(sum - x - y);
    lz = 6'(l); lza_err = err; frac_zero = fz; special_zero = sz;
    @(negedge clk);
    check(req, model(sum, l, err, fz, sz));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    exp_x = '0; exp_y = '0; exp_z = '0; lz = '0;
    lza_err = 1'b0; frac_zero = 1'b0; special_zero = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 12'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    apply("R2 plain", 127, 0, 1'b0, 1'b0, 1'b0);
    apply("R6 E=1", 1, 0, 1'b0, 1'b0, 1'b0);
    apply("R6 R8 E=255", 260, 5, 1'b0, 1'b0, 1'b0);
    apply("R3 E=256", 260, 5, 1'b1, 1'b0, 1'b0);
    apply("R4 R8 E=0", 10, 10, 1'b0, 1'b0, 1'b0);
    apply("R4 negative", -300, 48, 1'b0, 1'b0, 1'b0);
    apply("R5 frac_zero", 100, 3, 1'b0, 1'b1, 1'b0);
    apply("R5 special_zero", 300, 0, 1'b1, 1'b0, 1'b1);
    apply("R5 R8 zero no flag", -20, 7, 1'b0, 1'b1, 1'b0);
    apply("R3 large", 400, 0, 1'b1, 1'b0, 1'b0);

    for (int s = 0; s < 2; s++)
      for (int l = 0; l <= 48; l++)
        for (int e = 0; e < 2; e++)
          apply("R9 lz sweep", (s == 0) ? 30 : 290, l, e[0], 1'b0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      int sum;
      sum = int'($urandom_range(800, 0)) - 400;
      apply("R2 R7 random", sum, int'($urandom_range(48, 0)), 1'($urandom),
            ($urandom_range(15, 0) == 0), ($urandom_range(15, 0) == 0));
    end

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", 12'h000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule